// File: doc/BRIEF.md
# Serial Pattern-Run Detector

This block receives asynchronous serial characters in 8N1 framing (one start bit, eight data bits sent least significant bit first, one stop bit). It passes every good byte to its output with a one-cycle valid strobe. In parallel it watches for a run of a programmable pattern byte, such as a line terminator. It signals a detection only when the line timing around the run meets three thresholds, all counted in system clock cycles.

All idle time comes from one saturating counter. The counter starts from zero at the mid-bit instant where a stop bit is sampled. It stops and clears at the falling edge of the next start bit. Two checks use this counter at each start edge:
- The quiet-before test compares it with the pre-idle threshold.
- The spacing test compares it with the gap threshold.

The quiet-after test compares the running count with the post-idle threshold. Two characters sent back to back therefore see about half a bit time of idle.

Top module: `rxpat_top`

## Requirements
- R1: A frame whose start bit falls, whose eight data bits arrive least significant bit first, and whose stop bit is sampled high produces exactly one `rx_valid_o` pulse of one cycle, with the byte on `rx_data_o`. Each bit is sampled at its middle, `baud_div_i` clock cycles apart.
- R2: A low pulse on the line that has returned high by the middle of the start bit is dropped. It produces no byte and no detection, and the receiver accepts the next real frame.
- R3: A frame whose stop bit is sampled low is a framing error. It gives no `rx_valid_o` pulse and clears any pattern run in progress.
- R4: Idle time starts from zero at the stop-bit sampling instant. It counts one per clock and saturates at its maximum instead of wrapping. It is cleared at the next start-bit falling edge, where its value is captured for the pre-idle and gap tests.
- R5: The first pattern character of a run starts the run only if the captured idle time before its start bit is at least `pre_idle_i`. Otherwise it is discarded.
- R6: A later pattern character extends the run only if the idle time before it is below `gap_max_i`. Otherwise the run restarts from that character under the R5 rule.
- R7: A run qualifies when it holds exactly `run_len_i` pattern characters, and a `run_len_i` of 0 acts as 1. A further pattern character within the gap takes the run past that length and cancels the candidate.
- R8: After a qualifying run, a detection fires when the idle count reaches `post_idle_i`. A start bit that arrives before then cancels it. With small thresholds every pattern character of a back-to-back stream is reported. With a large post-idle threshold only the last one before silence is reported.
- R9: A good non-pattern character clears the run count and any pending detection.
- R10: `detect_o` is high for exactly one clock cycle per detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | DIV_W | Clock cycles per bit (at least 2) |
| pat_byte_i | input | 8 | Pattern character |
| run_len_i | input | RUN_W | Required run length (0 treated as 1) |
| pre_idle_i | input | CNT_W | Minimum quiet cycles before a run |
| post_idle_i | input | CNT_W | Quiet cycles after a run before detection |
| gap_max_i | input | CNT_W | Exclusive upper bound on idle between run characters |
| rx_data_o | output | 8 | Last good byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| detect_o | output | 1 | One-cycle detection pulse |

## Verification
The bench builds the block with its default widths: a 16-bit divisor, 24-bit idle thresholds and an 8-bit run length. It drives a divisor of 16, so a character lasts 160 cycles and a back-to-back pair leaves 7 cycles of idle. That short frame time keeps the quiet-before, spacing and quiet-after margins to tens of cycles. It also lets a single run cover back-to-back streams, streams split by chosen gaps, framing errors and start-bit glitches, each followed by a long silence. Saturation of the 24-bit counter lies out of reach in that time and is left to the assertion beside the timer.

// File: rtl/rxpat_pkg.sv
package rxpat_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Cycles from the start-bit edge to its middle; never below one.
  function automatic int unsigned half_bit(input int unsigned div);
    int unsigned h;
    h = div >> 1;
    return (h == 0) ? 1 : h;
  endfunction

  // A zero length behaves as a single character.
  function automatic int unsigned eff_len(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

endpackage

// File: rtl/rxpat_deser.sv
module rxpat_deser
  import rxpat_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             start_evt_o,
  output logic             end_evt_o,
  output logic             frame_done_o,
  output logic             frame_ok_o,
  output logic [7:0]       byte_o
);

  logic             rx_m, rx_s, rx_d;
  rx_state_e        state;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shift;
  logic             fall;
  logic             glitch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  assign fall         = rx_d & ~rx_s;
  assign start_evt_o  = (state == RX_IDLE) && fall;
  assign glitch       = (state == RX_START) && (cnt == '0) && rx_s;
  assign frame_done_o = (state == RX_STOP) && (cnt == '0);
  assign frame_ok_o   = rx_s;
  assign end_evt_o    = frame_done_o || glitch;
  assign byte_o       = shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shift   <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (fall) begin
            state <= RX_START;
            cnt   <= DIV_W'(half_bit(int'(div_i)) - 1);
          end
        end
        RX_START: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (rx_s) state <= RX_IDLE;
          else begin
            state   <= RX_DATA;
            cnt     <= div_i - 1'b1;
            bit_idx <= '0;
          end
        end
        RX_DATA: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            shift   <= {rx_s, shift[7:1]};
            cnt     <= div_i - 1'b1;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) state <= RX_STOP;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= RX_IDLE;
        end
      endcase
    end
  end

  // R2: a start bit found high at mid-bit returns the receiver to idle
  assert_glitch_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> (state == RX_IDLE));

  // R1: a completed frame is always followed by the idle state
  assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (state == RX_IDLE));

endmodule

// File: rtl/rxpat_idle_timer.sv
module rxpat_idle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt_i,
  input  logic             end_evt_i,
  input  logic [CNT_W-1:0] pre_idle_i,
  input  logic [CNT_W-1:0] gap_max_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] idle_o,
  output logic             pre_ok_o,
  output logic             gap_ok_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      idle_o   <= '0;
      pre_ok_o <= 1'b0;
      gap_ok_o <= 1'b0;
    end else if (start_evt_i) begin
      busy_o   <= 1'b1;
      idle_o   <= '0;
      pre_ok_o <= (idle_o >= pre_idle_i);
      gap_ok_o <= (idle_o < gap_max_i);
    end else if (end_evt_i) begin
      busy_o <= 1'b0;
      idle_o <= '0;
    end else if (!busy_o && idle_o != CNT_MAX) begin
      idle_o <= idle_o + 1'b1;
    end
  end

  // R4: a saturated count stays put while the line remains quiet
  assert_idle_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o == CNT_MAX && !start_evt_i && !end_evt_i) |=> (idle_o == CNT_MAX));

  // R4: the count never advances during a character
  assert_idle_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !end_evt_i && !start_evt_i) |=> $stable(idle_o));

endmodule

// File: rtl/rxpat_run_qual.sv
module rxpat_run_qual
  import rxpat_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic             frame_ok_i,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       pat_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic             start_evt_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] idle_i,
  input  logic             pre_ok_i,
  input  logic             gap_ok_i,
  input  logic [CNT_W-1:0] post_idle_i,
  output logic [RUN_W-1:0] run_cnt_o,
  output logic             detect_o
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             pending;
  logic             fire;
  logic             is_pat;
  logic [RUN_W-1:0] next_run;
  logic [RUN_W-1:0] need;

  assign need   = RUN_W'(eff_len(int'(run_len_i)));
  assign is_pat = (byte_i == pat_i);
  assign fire   = pending && !busy_i && !start_evt_i && (idle_i >= post_idle_i);

  always_comb begin
    if (run_cnt_o != '0 && gap_ok_i)
      next_run = (run_cnt_o == RUN_MAX) ? RUN_MAX : run_cnt_o + 1'b1;
    else
      next_run = pre_ok_i ? RUN_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt_o <= '0;
      pending   <= 1'b0;
      detect_o  <= 1'b0;
    end else begin
      detect_o <= fire;
      if (frame_done_i) begin
        if (frame_ok_i && is_pat) begin
          run_cnt_o <= next_run;
          pending   <= (next_run == need);
        end else begin
          run_cnt_o <= '0;
          pending   <= 1'b0;
        end
      end else if (start_evt_i) begin
        pending <= 1'b0;
      end else if (fire) begin
        pending   <= 1'b0;
        run_cnt_o <= '0;
      end
    end
  end

  // R3: a framing error empties the run
  assert_ferr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && !frame_ok_i) |=> (run_cnt_o == '0));

  // R9: a good non-pattern character empties the run
  assert_other_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && frame_ok_i && !is_pat) |=> (run_cnt_o == '0));

  // R8: a detection only follows a quiet line
  assert_detect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect_o) |-> $past(!busy_i));

  // R10: detection lasts one cycle
  assert_detect_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o);

endmodule

// File: rtl/rxpat_top.sv
module rxpat_top #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 24,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [7:0]       pat_byte_i,
  input  logic [RUN_W-1:0] run_len_i,
  input  logic [CNT_W-1:0] pre_idle_i,
  input  logic [CNT_W-1:0] post_idle_i,
  input  logic [CNT_W-1:0] gap_max_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             detect_o
);

  logic             start_evt, end_evt, frame_done, frame_ok;
  logic [7:0]       rx_byte;
  logic             busy, pre_ok, gap_ok;
  logic [CNT_W-1:0] idle_cnt;
  logic [RUN_W-1:0] run_cnt;

  rxpat_deser #(.DIV_W(DIV_W)) u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx_i),
    .div_i        (baud_div_i),
    .start_evt_o  (start_evt),
    .end_evt_o    (end_evt),
    .frame_done_o (frame_done),
    .frame_ok_o   (frame_ok),
    .byte_o       (rx_byte)
  );

  rxpat_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt_i (start_evt),
    .end_evt_i   (end_evt),
    .pre_idle_i  (pre_idle_i),
    .gap_max_i   (gap_max_i),
    .busy_o      (busy),
    .idle_o      (idle_cnt),
    .pre_ok_o    (pre_ok),
    .gap_ok_o    (gap_ok)
  );

  rxpat_run_qual #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done),
    .frame_ok_i   (frame_ok),
    .byte_i       (rx_byte),
    .pat_i        (pat_byte_i),
    .run_len_i    (run_len_i),
    .start_evt_i  (start_evt),
    .busy_i       (busy),
    .idle_i       (idle_cnt),
    .pre_ok_i     (pre_ok),
    .gap_ok_i     (gap_ok),
    .post_idle_i  (post_idle_i),
    .run_cnt_o    (run_cnt),
    .detect_o     (detect_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= frame_done && frame_ok;
      if (frame_done && frame_ok) rx_data_o <= rx_byte;
    end
  end

  // R1: the byte strobe is a single-cycle pulse
  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R3: a bad stop bit never yields a byte strobe
  assert_ferr_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |=> !rx_valid_o);

endmodule

// File: tb/rxpat_top_tb.sv
module rxpat_top_tb;

  localparam int BIT = 16;
  localparam logic [7:0] PAT = 8'h2B;
  localparam logic [7:0] OTH = 8'h78;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [7:0]  pat = PAT;
  logic [7:0]  run_len = 8'd1;
  logic [23:0] pre_idle = 24'd2, post_idle = 24'd2, gap_max = 24'd100;
  logic [7:0]  rx_data;
  logic        rx_valid, detect;

  int checks = 0, fails = 0;
  int det_cnt = 0, det_base = 0, valid_cnt = 0;
  logic [7:0] exp_q[$];
  logic prev_det = 1'b0;

  always #2.5 clk = ~clk;

  rxpat_top u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(16'(BIT)),
    .pat_byte_i(pat), .run_len_i(run_len), .pre_idle_i(pre_idle),
    .post_idle_i(post_idle), .gap_max_i(gap_max),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .detect_o(detect)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: frames one character; good frames are pushed to the scoreboard.
  task automatic send(input logic [7:0] b, input bit stop_ok = 1'b1);
    if (stop_ok) exp_q.push_back(b);
    rx = 1'b0; idle(BIT);
    for (int i = 0; i < 8; i++) begin rx = b[i]; idle(BIT); end
    rx = stop_ok; idle(BIT);
    rx = 1'b1;
  endtask

  task automatic expect_det(input int n, input string req);
    idle(400);
    check(det_cnt - det_base == n, req, det_cnt - det_base, n);
    det_base = det_cnt;
  endtask

  task automatic cfg(input int len, input int pre, input int post, input int gap);
    run_len = 8'(len); pre_idle = 24'(pre); post_idle = 24'(post); gap_max = 24'(gap);
    idle(400);
    det_base = det_cnt;
  endtask

  // Monitor: pops the scoreboard on every byte strobe.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        valid_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected byte", int'(rx_data), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, "R1 byte", int'(rx_data), int'(e));
        end
      end
      if (detect) begin
        det_cnt++;
        check(!prev_det, "R10 pulse width", 2, 1);
      end
      prev_det <= detect;
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    check(rx_valid == 1'b0 && detect == 1'b0, "R1 reset outputs", int'(rx_valid) + int'(detect), 0);
    rst_n = 1'b1;
    idle(20);

    // R1: assorted bytes, pattern absent
    cfg(1, 2, 2, 100);
    send(8'hA5); send(8'h3C); send(8'h00); send(8'hFF); send(8'h81);
    expect_det(0, "R1 no pattern");

    // R8: small thresholds report every pattern char of x+x+
    send(OTH); send(PAT); send(OTH); send(PAT);
    expect_det(2, "R8 small thresholds");

    // R8: large post-idle keeps only the final one
    cfg(1, 2, 100, 100);
    send(OTH); send(PAT); send(OTH); send(PAT);
    expect_det(1, "R8 large post-idle");

    // R5: large pre-idle rejects x+, accepts +x after silence
    cfg(1, 100, 2, 100);
    send(OTH); send(PAT);
    expect_det(0, "R5 short pre-idle");
    send(PAT); send(OTH);
    expect_det(1, "R5 long pre-idle");

    // R6 / R7: run of two
    cfg(2, 50, 50, 40);
    send(PAT); send(PAT);
    expect_det(1, "R7 run of two");
    send(PAT);
    expect_det(0, "R7 run too short");
    send(PAT); idle(30); send(PAT);
    expect_det(1, "R6 gap inside limit");
    send(PAT); idle(60); send(PAT);
    expect_det(0, "R6 gap broken");
    send(PAT); send(PAT); send(PAT);
    expect_det(0, "R7 run too long");

    // R9: other char breaks the run
    cfg(2, 2, 2, 100);
    send(PAT); send(OTH); send(PAT);
    expect_det(0, "R9 non-pattern clears");

    // R3: framing errors
    cfg(1, 2, 2, 100);
    send(PAT, 1'b0); idle(16);
    expect_det(0, "R3 bad stop single");
    cfg(2, 2, 2, 100);
    send(PAT); send(PAT, 1'b0); idle(16); send(PAT);
    expect_det(0, "R3 bad stop clears run");

    // R2: start-bit glitch
    cfg(1, 2, 2, 100);
    begin
      int v0;
      v0 = valid_cnt;
      rx = 1'b0; idle(4); rx = 1'b1;
      expect_det(0, "R2 glitch no detect");
      check(valid_cnt == v0, "R2 glitch no byte", valid_cnt - v0, 0);
    end
    send(PAT);
    expect_det(1, "R2 receiver recovers");

    // R7: zero length acts as one
    cfg(0, 2, 2, 100);
    send(PAT);
    expect_det(1, "R7 zero length");

    // R4: idle measured from stop sample; 7-cycle back-to-back gap vs pre-idle 6 and 9
    cfg(1, 6, 2, 100);
    send(OTH); send(PAT);
    expect_det(1, "R4 idle above pre");
    cfg(1, 9, 2, 100);
    send(OTH); send(PAT);
    expect_det(0, "R4 idle below pre");

    idle(50);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule